// File: doc/BRIEF.md
# Checksum Verifier and Fault Locator

This block inspects the output of a parallel matrix multiplier protected by row and column checksums. The product arrives as N+1 rows of N+1 elements each, one whole row per accepted cycle. The first N rows are data rows, each ending in its row checksum. The final row holds the column checksums, and its last element is the checksum of the checksums. The block recomputes every row sum and every column sum, each modulo 2^DW, and compares each with the stored checksum.

Each output column is computed by exactly one multiply-accumulate unit. A mismatching column therefore names a faulty unit. Mismatching rows show which results are corrupted. One faulty unit usually spoils several rows but only one column. When the last row of a frame has been taken in, the block presents a one-cycle result: a row mismatch vector, a column mismatch vector and an overall error flag. Deciding how to recover is left to the surrounding system.

Top module: `ckv_checksum_verifier`

## Requirements
- R1: While `rst_n` is low, `res_valid` and `error` are 0 and both mismatch vectors are all zero.
- R2: Element j of a row sits at `row_data[j*DW +: DW]`, and element N is that row's checksum. For each row i in 0..N, `row_mismatch[i]` is 1 exactly when the modulo 2^DW sum of elements 0..N-1 differs from element N.
- R3: For each column j in 0..N, `col_mismatch[j]` is 1 exactly when the modulo 2^DW sum of element j over rows 0..N-1 differs from element j of row N. A single wrong element in a data row flags only its own column.
- R4: The element at position (N,N) is checked twice. Corrupting only that element sets `row_mismatch[N]` and `col_mismatch[N]` and no other bit.
- R5: In the result cycle, `error` is the OR of all bits of both mismatch vectors.
- R6: Rows are counted only in cycles with `row_valid` high, and idle cycles between rows have no effect. `res_valid` is high for exactly the one cycle after the clock edge that accepts row N, and it is low at all other times.
- R7: Each frame is judged on its own. Column sums and row results restart with the first row after a result, so a faulty frame leaves no trace on the next one.
- R8: `error`, `row_mismatch` and `col_mismatch` keep their values from the end of the result cycle until the next result.
- R9: All sums wrap modulo 2^DW, so a checksum that itself wrapped is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid | input | 1 | A product row is present on `row_data` |
| row_data | input | (N+1)*DW | One product row, element j at bits j*DW upward |
| res_valid | output | 1 | One-cycle pulse: the result outputs belong to the frame just completed |
| error | output | 1 | At least one checksum mismatched |
| row_mismatch | output | N+1 | Bit i set: row i checksum mismatched |
| col_mismatch | output | N+1 | Bit j set: column j checksum mismatched (unit j faulty) |

## Verification
Consistent frames built from random data must produce all-zero vectors. This includes frames whose values are near 2^DW, where sums wrap. Frames with one to three corrupted elements at random places must flag exactly the rows and columns a bench-side model predicts, which separates row logic from column logic. Directed cases follow.

- A stuck low bit in the first unit on a small product must flag column 0 only, together with the affected rows.
- A frame with only the corner element corrupted shows that it is checked in both directions.
- Idle gaps inside a frame, and a clean frame right after a faulty one, separate correct row counting from stale accumulation.

// File: rtl/ckv_pkg.sv
package ckv_pkg;

  // Add two values and keep only the low w bits (modulo 2^w).
  function automatic logic [63:0] ckv_fold_add(logic [63:0] acc, logic [63:0] val, int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (acc + val) & mask;
  endfunction

endpackage

// File: rtl/ckv_row_check.sv
module ckv_row_check
  import ckv_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic [(N+1)*DW-1:0] row_data,
  output logic [DW-1:0]       row_sum,
  output logic                row_bad
);

  logic [63:0] acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < N; j++) begin
      acc = ckv_fold_add(acc, 64'(row_data[j*DW +: DW]), DW);
    end
    row_sum = acc[DW-1:0];
    row_bad = (row_sum != row_data[N*DW +: DW]);
  end

endmodule

// File: rtl/ckv_col_store.sv
module ckv_col_store
  import ckv_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_valid,
  input  logic [CW-1:0]       frame_cnt,
  input  logic [(N+1)*DW-1:0] row_data,
  output logic [N:0]          col_bad
);

  logic is_first;
  logic is_data;

  assign is_first = (frame_cnt == '0);
  assign is_data  = (frame_cnt < CW'(N));

  for (genvar j = 0; j <= N; j++) begin : g_col
    logic [DW-1:0] acc_q;
    logic [DW-1:0] elem;
    logic [63:0]   sum_w;

    assign elem  = row_data[j*DW +: DW];
    assign sum_w = ckv_fold_add(64'(acc_q), 64'(elem), DW);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (row_valid && is_data) begin
        acc_q <= is_first ? elem : sum_w[DW-1:0];
      end
    end

    assign col_bad[j] = (acc_q != elem);
  end

endmodule

// File: rtl/ckv_frame_ctrl.sv
module ckv_frame_ctrl #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_valid,
  input  logic          row_bad,
  input  logic [N:0]    col_bad,
  output logic [CW-1:0] frame_cnt,
  output logic          last_row_evt,
  output logic          res_valid,
  output logic          error,
  output logic [N:0]    row_mismatch,
  output logic [N:0]    col_mismatch
);

  logic [CW-1:0] cnt_q;
  logic [N:0]    rm_q;
  logic [N:0]    rm_next;

  assign frame_cnt    = cnt_q;
  assign last_row_evt = row_valid && (cnt_q == CW'(N));

  always_comb begin
    rm_next = (cnt_q == '0) ? '0 : rm_q;
    rm_next[cnt_q] = row_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      rm_q         <= '0;
      res_valid    <= 1'b0;
      error        <= 1'b0;
      row_mismatch <= '0;
      col_mismatch <= '0;
    end else begin
      res_valid <= last_row_evt;
      if (row_valid) begin
        cnt_q <= last_row_evt ? '0 : cnt_q + 1'b1;
        rm_q  <= rm_next;
      end
      if (last_row_evt) begin
        row_mismatch <= rm_next;
        col_mismatch <= col_bad;
        error        <= (|rm_next) || (|col_bad);
      end
    end
  end

endmodule

// File: rtl/ckv_checksum_verifier.sv
module ckv_checksum_verifier #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_valid,
  input  logic [(N+1)*DW-1:0] row_data,
  output logic                res_valid,
  output logic                error,
  output logic [N:0]          row_mismatch,
  output logic [N:0]          col_mismatch
);

  localparam int CW = (N + 1 > 1) ? $clog2(N + 1) : 1;

  logic [CW-1:0] frame_cnt;
  logic          last_row_evt;
  logic [DW-1:0] row_sum;
  logic          row_bad;
  logic [N:0]    col_bad;

  ckv_row_check #(.N(N), .DW(DW)) u_row (
    .row_data (row_data),
    .row_sum  (row_sum),
    .row_bad  (row_bad)
  );

  ckv_col_store #(.N(N), .DW(DW), .CW(CW)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_valid (row_valid),
    .frame_cnt (frame_cnt),
    .row_data  (row_data),
    .col_bad   (col_bad)
  );

  ckv_frame_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_valid    (row_valid),
    .row_bad      (row_bad),
    .col_bad      (col_bad),
    .frame_cnt    (frame_cnt),
    .last_row_evt (last_row_evt),
    .res_valid    (res_valid),
    .error        (error),
    .row_mismatch (row_mismatch),
    .col_mismatch (col_mismatch)
  );

endmodule

// File: rtl/ckv_checker.sv
module ckv_checker #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic          error,
  input logic [N:0]    row_mismatch,
  input logic [N:0]    col_mismatch,
  input logic [CW-1:0] frame_cnt,
  input logic          last_row_evt
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !error && row_mismatch == '0 && col_mismatch == '0));

  // R6
  valid_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_row_evt |=> res_valid);

  // R6
  valid_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(last_row_evt));

  // R6
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  error_is_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (error == ((|row_mismatch) || (|col_mismatch))));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(error) && $stable(row_mismatch) && $stable(col_mismatch)));

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= CW'(N));

endmodule

bind ckv_checksum_verifier ckv_checker #(.N(N), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid    (res_valid),
  .error        (error),
  .row_mismatch (row_mismatch),
  .col_mismatch (col_mismatch),
  .frame_cnt    (frame_cnt),
  .last_row_evt (last_row_evt)
);

// File: tb/test_ckv_checksum_verifier.sv
module test_ckv_checksum_verifier;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int MASK = (1 << DW) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                row_valid = 1'b0;
  logic [(N+1)*DW-1:0] row_data = '0;
  logic                res_valid;
  logic                error;
  logic [N:0]          row_mismatch;
  logic [N:0]          col_mismatch;

  int total = 0;
  int bad   = 0;
  int mat [0:N][0:N];

  always #2 clk = ~clk;

  ckv_checksum_verifier #(.N(N), .DW(DW)) i_ckv_checksum_verifier (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_data(row_data),
    .res_valid(res_valid), .error(error),
    .row_mismatch(row_mismatch), .col_mismatch(col_mismatch)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Column-major model of the column checks (R3).
  function automatic logic [N:0] model_cols();
    logic [N:0] v = '0;
    for (int j = 0; j <= N; j++) begin
      int s = 0;
      for (int i = 0; i < N; i++) s += mat[i][j];
      v[j] = ((s & MASK) != mat[N][j]);
    end
    return v;
  endfunction

  // Row-by-row model of the row checks (R2).
  function automatic logic [N:0] model_rows();
    logic [N:0] v = '0;
    for (int i = 0; i <= N; i++) begin
      int s = 0;
      for (int j = 0; j < N; j++) s += mat[i][j];
      v[i] = ((s & MASK) != mat[i][N]);
    end
    return v;
  endfunction

  task automatic make_clean(input int hi_only);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        mat[i][j] = hi_only ? (MASK - ($urandom % 4)) : ($urandom & MASK);
    for (int i = 0; i < N; i++) begin
      int s = 0;
      for (int j = 0; j < N; j++) s += mat[i][j];
      mat[i][N] = s & MASK;
    end
    for (int j = 0; j <= N; j++) begin
      int s = 0;
      for (int i = 0; i < N; i++) s += mat[i][j];
      mat[N][j] = s & MASK;
    end
  endtask

  task automatic run_frame(input bit gaps, input string tag);
    logic [N:0] er, ec;
    logic [N:0] held_r, held_c;
    er = model_rows();
    ec = model_cols();
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      row_valid = 1'b1;
      for (int j = 0; j <= N; j++) row_data[j*DW +: DW] = mat[i][j][DW-1:0];
      if (gaps && i < N && ($urandom % 2 == 1)) begin
        @(negedge clk);
        row_valid = 1'b0;
        row_data  = '1;
        // R6 idle cycle: no result yet
        check(res_valid == 1'b0, "R6 idle gap", 32'(res_valid), 32'd0);
      end
    end
    @(posedge clk);
    #1;
    check(res_valid == 1'b1, {"R6 valid ", tag}, 32'(res_valid), 32'd1);
    check(row_mismatch == er, {"R2 rows ", tag}, 32'(row_mismatch), 32'(er));
    check(col_mismatch == ec, {"R3 cols ", tag}, 32'(col_mismatch), 32'(ec));
    check(error == ((|er) || (|ec)), {"R5 error ", tag}, 32'(error), 32'((|er) || (|ec)));
    held_r = row_mismatch;
    held_c = col_mismatch;
    @(negedge clk);
    row_valid = 1'b0;
    row_data  = '0;
    @(posedge clk);
    #1;
    check(res_valid == 1'b0, {"R6 pulse ", tag}, 32'(res_valid), 32'd0);
    check(row_mismatch == held_r && col_mismatch == held_c, {"R8 hold ", tag},
          32'({row_mismatch, col_mismatch}), 32'({held_r, held_c}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(!res_valid && !error && row_mismatch == '0 && col_mismatch == '0, "R1 reset",
          32'({res_valid, error, row_mismatch, col_mismatch}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: stuck low bit of unit 0 on a 2x2 product embedded in zeros.
    for (int i = 0; i <= N; i++) for (int j = 0; j <= N; j++) mat[i][j] = 0;
    mat[0][0] = 21; mat[0][1] = 22; mat[0][N] = 41;
    mat[1][0] = 45; mat[1][1] = 50; mat[1][N] = 93;
    mat[N][0] = 63; mat[N][1] = 72; mat[N][N] = 134;
    run_frame(1'b0, "fault example");
    // R3 unit 0 located, unit 1 clean
    check(col_mismatch == 5'b00001, "R3 example col", 32'(col_mismatch), 32'h01);
    check(row_mismatch == 5'b10011, "R2 example row", 32'(row_mismatch), 32'h13);

    // R7: clean frame after a faulty one
    make_clean(0);
    run_frame(1'b1, "R7 clean");
    check(!error, "R7 no carry", 32'(error), 32'd0);

    // R9: wrapped sums
    make_clean(1);
    run_frame(1'b0, "R9 wrap");
    check(!error, "R9 wrap clean", 32'(error), 32'd0);

    // R4: only the corner corrupted
    make_clean(0);
    mat[N][N] = (mat[N][N] + 1) & MASK;
    run_frame(1'b0, "R4 corner");
    check(row_mismatch == 5'b10000 && col_mismatch == 5'b10000, "R4 corner bits",
          32'({row_mismatch, col_mismatch}), 32'h210);

    // Random frames with up to three corrupted elements, with gaps
    for (int f = 0; f < 40; f++) begin
      int nerr;
      make_clean(f % 5 == 0);
      nerr = $urandom % 4;
      for (int k = 0; k < nerr; k++) begin
        int ri = $urandom % (N + 1);
        int cj = $urandom % (N + 1);
        mat[ri][cj] = (mat[ri][cj] + 1 + ($urandom % MASK)) & MASK;
      end
      run_frame(f[0], "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule